// File: doc/BRIEF.md
# Endpoint Configuration Register Bank

This block keeps one 8-bit configuration byte for each of sixteen endpoint slots of a full-speed USB peripheral controller. The slots are control OUT, control IN and endpoints 1 through 14. A host microcontroller talks to the bank over a byte-wide command port. It first strobes a one-byte command code, then strobes exactly one data byte. The code picks the slot and says whether the byte is written into that slot or read back from it.

The stored fields go out to the rest of the controller as flat per-slot vectors: FIFO enable, direction, double buffering, isochronous type and a 4-bit size code. The direction bit also sets the DMA transfer direction. A write that changes how FIFO memory would be allocated raises a single-cycle global invalidate pulse. That pulse tells every endpoint FIFO that its stored data is now stale, not only the FIFO of the slot that was written.

Top module: `epcfg_bank`

## Requirements
- R1: After reset, every configuration byte is 0x00, and `invalidate_all` and `rd_valid` are low.
- R2: Command code 0x20+n followed by a data byte stores that byte in slot n. The new value shows on the field outputs in the cycle after the data strobe. The field positions in the byte are: bit 7 enable, bit 6 direction (1 = IN, which also means DMA write), bit 5 double buffer, bit 4 isochronous, bits 3:0 size code.
- R3: Command code 0x30+n followed by a data strobe returns slot n's byte on `rd_data`. `rd_valid` is high for exactly the one cycle after the data strobe.
- R4: Slot 0 is control OUT, slot 1 is control IN, and slots 2 to 15 are endpoints 1 to 14. A write to one slot leaves all other slots unchanged.
- R5: A write that changes the enable bit or the size code of its slot raises `invalidate_all` for exactly one cycle, the cycle after the data strobe.
- R6: A write of a byte equal to the stored value raises no `invalidate_all`.
- R7: A write that changes only the direction, double-buffer or isochronous bits raises no `invalidate_all`.
- R8: A data strobe with no valid command pending changes no slot and raises neither `rd_valid` nor `invalidate_all`.
- R9: A command code outside 0x20 to 0x3F is not claimed. It cancels any pending command, and the data strobe that follows it is ignored.
- R10: Each command moves one byte. A second data strobe with no new command in between is ignored.
- R11: A read changes no configuration field and raises no `invalidate_all`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command code strobe |
| cmd_code | input | 8 | Command code |
| data_valid | input | 1 | Data phase strobe |
| wr_data | input | 8 | Byte to write during the data phase |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | 8 | Byte read back |
| ep_enable | output | NUM_EP | Per-slot FIFO enable |
| ep_dir_in | output | NUM_EP | Per-slot direction (1 = IN / DMA write) |
| ep_dbuf | output | NUM_EP | Per-slot double buffering |
| ep_iso | output | NUM_EP | Per-slot isochronous type |
| ep_size | output | 4*NUM_EP | Per-slot size code, slot n at bits 4n+3:4n |
| invalidate_all | output | 1 | One-cycle pulse: all FIFO contents invalid |

## Verification
The bench builds the bank with its default parameters: sixteen slots, write codes based at 0x20 and read codes at 0x30. With these values every slot is reachable, including the highest one (code 0x2F/0x3F), and the edges of the claimed code range meet unclaimed codes such as 0x45. Directed writes flip the allocation-relevant bits and the other bits separately, so the presence or absence of the invalidate pulse is tested against each field. A full sweep writes distinct values into all sixteen slots and reads them back to catch any slot aliasing.

// File: rtl/epcfg_bank.sv
module epcfg_bank #(
  parameter int          NUM_EP  = 16,
  parameter logic [7:0]  WR_BASE = 8'h20,
  parameter logic [7:0]  RD_BASE = 8'h30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [7:0]            cmd_code,
  input  logic                  data_valid,
  input  logic [7:0]            wr_data,
  output logic                  rd_valid,
  output logic [7:0]            rd_data,
  output logic [NUM_EP-1:0]     ep_enable,
  output logic [NUM_EP-1:0]     ep_dir_in,
  output logic [NUM_EP-1:0]     ep_dbuf,
  output logic [NUM_EP-1:0]     ep_iso,
  output logic [4*NUM_EP-1:0]   ep_size,
  output logic                  invalidate_all
);
  localparam int IDX_W = $clog2(NUM_EP);

  logic [7:0]       cfg_q [NUM_EP];
  logic             pend_q, pend_wr_q;
  logic [IDX_W-1:0] pend_idx_q;

  wire       wr_hit    = cmd_code[7:IDX_W] == WR_BASE[7:IDX_W];
  wire       rd_hit    = cmd_code[7:IDX_W] == RD_BASE[7:IDX_W];
  wire [7:0] cur       = cfg_q[pend_idx_q];
  wire       do_wr     = data_valid && pend_q && pend_wr_q;
  wire       do_rd     = data_valid && pend_q && !pend_wr_q;
  wire       alloc_chg = (cur[7] != wr_data[7]) || (cur[3:0] != wr_data[3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q         <= 1'b0;
      pend_wr_q      <= 1'b0;
      pend_idx_q     <= '0;
      rd_valid       <= 1'b0;
      rd_data        <= '0;
      invalidate_all <= 1'b0;
      for (int i = 0; i < NUM_EP; i++) cfg_q[i] <= '0;
    end else begin
      invalidate_all <= do_wr && alloc_chg;
      rd_valid       <= do_rd;
      if (do_rd) rd_data <= cur;
      if (do_wr) cfg_q[pend_idx_q] <= wr_data;
      if (data_valid) pend_q <= 1'b0;
      if (cmd_valid) begin
        pend_q     <= wr_hit || rd_hit;
        pend_wr_q  <= wr_hit;
        pend_idx_q <= cmd_code[IDX_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_fld
    assign ep_enable[g]     = cfg_q[g][7];
    assign ep_dir_in[g]     = cfg_q[g][6];
    assign ep_dbuf[g]       = cfg_q[g][5];
    assign ep_iso[g]        = cfg_q[g][4];
    assign ep_size[4*g +: 4] = cfg_q[g][3:0];
  end
endmodule

// File: rtl/epcfg_bank_chk.sv
module epcfg_bank_chk #(
  parameter int NUM_EP = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                data_valid,
  input logic                rd_valid,
  input logic                invalidate_all,
  input logic [NUM_EP-1:0]   ep_enable,
  input logic [NUM_EP-1:0]   ep_dir_in,
  input logic [NUM_EP-1:0]   ep_dbuf,
  input logic [NUM_EP-1:0]   ep_iso,
  input logic [4*NUM_EP-1:0] ep_size
);
  // R3
  rd_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(data_valid));

  // R5
  inv_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate_all |-> $past(data_valid));

  // R5
  inv_on_alloc_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_enable != $past(ep_enable) || ep_size != $past(ep_size)) |-> invalidate_all);

  // R6
  no_spurious_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalidate_all |-> (ep_enable != $past(ep_enable) || ep_size != $past(ep_size)));

  // R11
  rd_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !invalidate_all);

  // R8
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_valid) |-> ($stable(ep_dir_in) && $stable(ep_dbuf) && $stable(ep_iso)
                            && $stable(ep_enable) && $stable(ep_size)));
endmodule

bind epcfg_bank epcfg_bank_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .rd_valid(rd_valid),
  .invalidate_all(invalidate_all), .ep_enable(ep_enable), .ep_dir_in(ep_dir_in),
  .ep_dbuf(ep_dbuf), .ep_iso(ep_iso), .ep_size(ep_size)
);

// File: tb/epcfg_bank_bench.sv
module epcfg_bank_bench;
  localparam int N = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, data_valid = 0;
  logic [7:0] cmd_code = 0, wr_data = 0;
  logic rd_valid, invalidate_all;
  logic [7:0] rd_data;
  logic [N-1:0] ep_enable, ep_dir_in, ep_dbuf, ep_iso;
  logic [4*N-1:0] ep_size;

  int checks = 0, errors = 0;
  logic [7:0] model [N];

  always #2 clk = ~clk;

  epcfg_bank u_epcfg_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .data_valid(data_valid), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .ep_enable(ep_enable), .ep_dir_in(ep_dir_in),
    .ep_dbuf(ep_dbuf), .ep_iso(ep_iso), .ep_size(ep_size),
    .invalidate_all(invalidate_all)
  );

  function automatic logic [7:0] slot(int i);
    return {ep_enable[i], ep_dir_in[i], ep_dbuf[i], ep_iso[i], ep_size[4*i +: 4]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < N; i++) check(req, slot(i), model[i]);
  endtask

  task automatic cmd(logic [7:0] c);
    cmd_valid = 1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic data(logic [7:0] d);
    data_valid = 1; wr_data = d;
    @(negedge clk);
    data_valid = 0;
  endtask

  task automatic t_reset;
    check_all("R1");
    check("R1", {rd_valid, invalidate_all}, 0);
  endtask

  task automatic t_write_alloc;
    cmd(8'h20); data(8'h8F); model[0] = 8'h8F;
    check("R2", slot(0), 8'h8F);
    check("R5", invalidate_all, 1);
    @(negedge clk);
    check("R5", invalidate_all, 0);
    cmd(8'h2F); data(8'h4A); model[15] = 8'h4A;
    check("R5", invalidate_all, 1);
    check_all("R4");
    @(negedge clk);
  endtask

  task automatic t_read;
    cmd(8'h30); data(8'h00);
    check("R3", rd_valid, 1);
    check("R3", rd_data, 8'h8F);
    check("R11", invalidate_all, 0);
    @(negedge clk);
    check("R3", rd_valid, 0);
    check_all("R11");
  endtask

  task automatic t_same_and_attr;
    cmd(8'h20); data(8'h8F);
    check("R6", invalidate_all, 0);
    cmd(8'h20); data(8'hFF); model[0] = 8'hFF;
    check("R7", invalidate_all, 0);
    check("R7", slot(0), 8'hFF);
    check("R2", ep_dir_in[0], 1);
    @(negedge clk);
  endtask

  task automatic t_ignored;
    data(8'h99);
    check("R8", {rd_valid, invalidate_all}, 0);
    check_all("R8");
    cmd(8'h45); data(8'h9C);
    check("R9", invalidate_all, 0);
    check_all("R9");
    cmd(8'h25); cmd(8'h1F); data(8'h9C);
    check("R9", {rd_valid, invalidate_all}, 0);
    check_all("R9");
    cmd(8'h21); data(8'h81); model[1] = 8'h81;
    data(8'h00);
    check("R10", invalidate_all, 0);
    check_all("R10");
    @(negedge clk);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < N; i++) begin
      cmd(8'h20 + 8'(i)); data(8'(i * 17 + 3)); model[i] = 8'(i * 17 + 3);
    end
    check_all("R4");
    for (int i = 0; i < N; i++) begin
      cmd(8'h30 + 8'(i)); data(8'h00);
      check("R3", {rd_valid, rd_data}, {1'b1, model[i]});
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_alloc;
    t_read;
    t_same_and_attr;
    t_ignored;
    t_sweep;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule